// File: doc/BRIEF.md
# Wide-Word Video Scan-Out Controller

This block sits at the end of a pixel pipeline and turns a stream of wide memory words into a steady one-pixel-per-clock display timing stream. Each word delivered on the write side carries eight 24-bit RGB pixels. The words go into an internal word FIFO. A scan generator then unpacks them one pixel per active clock. It also produces horizontal and vertical sync and a data-enable strobe for a raster of 640x480 visible pixels inside an 800x585-clock frame.

Upstream latency is irregular, so the controller does not begin scanning straight after reset. It first waits a fixed start-up interval, 16,000 clocks by default, so the FIFO can stock up. This wait happens once, not every frame. After that, every visible pixel position pulls one pixel. Blanking positions pull nothing, which gives the FIFO time to catch up. If the FIFO is empty at a visible position, the block emits black, holds its place in the pixel sequence, and raises a sticky starvation flag. Software clears that flag with a clear input.

Top module: `vid_wide_out`

## Requirements
- R1: While reset is asserted and just after it, vid_de, vid_hsync, vid_vsync and underflow are 0, vid_rgb is 0 and wr_ready is 1.
- R2: After reset is released, vid_de, vid_hsync and vid_vsync stay 0 for PREFILL clock edges. vid_de first reads 1 after edge PREFILL+1, and this start-up wait is never repeated.
- R3: Pixel k of a word (k = 0..PPW-1) lies in bits [24k+23:24k] and is shown on the k-th active cycle that uses that word, pixel 0 first. Within a pixel, red is bits [23:16], green is [15:8] and blue is [7:0].
- R4: Each line lasts H_TOTAL clocks. vid_de is high for the first H_ACTIVE of them. vid_hsync (active high) rises H_FP clocks after vid_de falls and stays high for H_SYNC clocks.
- R5: Each frame lasts V_TOTAL lines, and the first V_ACTIVE of them carry vid_de. vid_vsync (active high) covers V_SYNC whole lines and is followed by V_TOTAL-V_ACTIVE-V_FP-V_SYNC back-porch lines before the next active line.
- R6: Blanking cycles consume no pixels: the pixel sequence runs on across line and frame boundaries with no gap and no repeat.
- R7: wr_ready is 0 while the FIFO holds DEPTH words. A word offered while wr_ready is 0 is not stored.
- R8: When the FIFO is empty on an active cycle, vid_rgb shows 0 for that cycle and underflow becomes 1. The flag stays 1 until it is cleared.
- R9: A one-cycle pulse on underflow_clr, with no new starvation in that cycle, returns underflow to 0.
- R10: A starved active cycle does not advance the pixel sequence. The first pixel shown once data returns is the one that was due when starvation began.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write word offered |
| wr_data | input | PPW*24 | Eight packed pixels, pixel 0 in the low bits |
| wr_ready | output | 1 | FIFO can take a word |
| underflow_clr | input | 1 | Clears the starvation flag |
| underflow | output | 1 | Sticky starvation flag |
| vid_de | output | 1 | Data enable, high on visible pixels |
| vid_hsync | output | 1 | Horizontal sync, active high |
| vid_vsync | output | 1 | Vertical sync, active high |
| vid_rgb | output | 24 | Pixel out, R[23:16] G[15:8] B[7:0] |

## Verification
The scan is driven with three supply patterns. First, a continuous feed that keeps the FIFO full, including words held on the write port while it is full; this shows whether words are dropped, repeated or reordered across blanking. Second, a starved interval where feeding stops; this separates a correct hold-and-resume of the pixel sequence from a design that skips pixels or emits stale data. Third, a resumed feed followed by a flag clear. Every pixel value is distinct and never zero, so black output and any misplaced lane or pixel show up directly. The sync and enable timing is measured against the line and frame parameters on a reduced raster.

// File: rtl/vout_pkg.sv
package vout_pkg;
   localparam int CHAN_W = 8;
   localparam int PIX_W  = 3 * CHAN_W;

   typedef logic [CHAN_W-1:0] chan_t;

   typedef struct packed {
      chan_t red;
      chan_t green;
      chan_t blue;
   } rgb_t;

   localparam rgb_t BLACK = '{red: '0, green: '0, blue: '0};
endpackage

// File: rtl/vout_word_fifo.sv
module vout_word_fifo #(
   parameter int WORD_W = 192,
   parameter int DEPTH  = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [WORD_W-1:0] wr_data,
   output logic              wr_ready,
   output logic [WORD_W-1:0] rd_data,
   output logic              rd_empty,
   input  logic              rd_pop
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("vout_word_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [WORD_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wr_ptr, rd_ptr;
   logic [CW-1:0]     count;
   logic              push, pop;

   assign wr_ready = (count != FULL_CNT);
   assign rd_empty = (count == '0);
   assign rd_data  = mem[rd_ptr];
   assign push     = wr_valid && wr_ready;
   assign pop      = rd_pop && !rd_empty;

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R7: occupancy never exceeds the depth
   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (count == FULL_CNT && wr_valid && !rd_pop) |=> (count == FULL_CNT));
   // R8: reads are never requested from an empty store
   p_no_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_empty |-> !rd_pop);
endmodule

// File: rtl/vout_timing.sv
module vout_timing #(
   parameter int H_ACTIVE = 640,
   parameter int H_FP     = 16,
   parameter int H_SYNC   = 96,
   parameter int H_TOTAL  = 800,
   parameter int V_ACTIVE = 480,
   parameter int V_FP     = 10,
   parameter int V_SYNC   = 2,
   parameter int V_TOTAL  = 585,
   parameter int PREFILL  = 16000
) (
   input  logic clk,
   input  logic rst_n,
   output logic active,
   output logic hsync,
   output logic vsync
);
   localparam int HW  = $clog2(H_TOTAL);
   localparam int VW  = $clog2(V_TOTAL);
   localparam int PCW = $clog2(PREFILL + 1);

   localparam logic [HW-1:0]  H_LAST = HW'(H_TOTAL - 1);
   localparam logic [HW-1:0]  H_VIS  = HW'(H_ACTIVE);
   localparam logic [HW-1:0]  H_S0   = HW'(H_ACTIVE + H_FP);
   localparam logic [HW-1:0]  H_S1   = HW'(H_ACTIVE + H_FP + H_SYNC);
   localparam logic [VW-1:0]  V_LAST = VW'(V_TOTAL - 1);
   localparam logic [VW-1:0]  V_VIS  = VW'(V_ACTIVE);
   localparam logic [VW-1:0]  V_S0   = VW'(V_ACTIVE + V_FP);
   localparam logic [VW-1:0]  V_S1   = VW'(V_ACTIVE + V_FP + V_SYNC);
   localparam logic [PCW-1:0] P_LAST = PCW'(PREFILL - 1);

   generate
      if (H_TOTAL <= H_ACTIVE + H_FP + H_SYNC) begin : g_bad_h
         $error("vout_timing: horizontal back porch must be at least one clock");
      end
      if (V_TOTAL <= V_ACTIVE + V_FP + V_SYNC) begin : g_bad_v
         $error("vout_timing: vertical back porch must be at least one line");
      end
      if (PREFILL < 1) begin : g_bad_p
         $error("vout_timing: PREFILL must be at least 1");
      end
   endgenerate

   logic           run;
   logic [PCW-1:0] pcnt;
   logic [HW-1:0]  hpos;
   logic [VW-1:0]  vpos;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run  <= 1'b0;
         pcnt <= '0;
         hpos <= '0;
         vpos <= '0;
      end else if (!run) begin
         if (pcnt == P_LAST) run  <= 1'b1;
         else                pcnt <= pcnt + 1'b1;
      end else if (hpos == H_LAST) begin
         hpos <= '0;
         vpos <= (vpos == V_LAST) ? '0 : vpos + 1'b1;
      end else begin
         hpos <= hpos + 1'b1;
      end
   end

   assign active = run && (hpos < H_VIS) && (vpos < V_VIS);
   assign hsync  = run && (hpos >= H_S0) && (hpos < H_S1);
   assign vsync  = run && (vpos >= V_S0) && (vpos < V_S1);

   // R2: the start-up wait ends once and never comes back
   p_run_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> run);
   // R2: the counters stay parked during the wait
   p_parked_prefill_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (hpos == '0 && vpos == '0));
   // R4: the line counter wraps at the end of the line
   p_hwrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && hpos == H_LAST) |=> (hpos == '0));
endmodule

// File: rtl/vout_unpack.sv
module vout_unpack
   import vout_pkg::*;
#(
   parameter int PPW = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               active,
   input  logic [PPW*PIX_W-1:0] word,
   input  logic               empty,
   output logic               pop,
   output logic               starve,
   output rgb_t               pix
);
   localparam int SW = $clog2(PPW);
   localparam logic [SW-1:0] S_LAST = SW'(PPW - 1);

   generate
      if (PPW < 2 || (1 << SW) != PPW) begin : g_bad_ppw
         $error("vout_unpack: PPW must be a power of two, at least 2");
      end
   endgenerate

   rgb_t          lane [PPW];
   logic [SW-1:0] sel;
   logic          take;

   generate
      for (genvar g = 0; g < PPW; g++) begin : g_lane
         assign lane[g] = rgb_t'(word[g*PIX_W +: PIX_W]);
      end
   endgenerate

   assign take   = active && !empty;
   assign starve = active && empty;
   assign pop    = take && (sel == S_LAST);
   assign pix    = take ? lane[sel] : BLACK;

   always_ff @(posedge clk) begin
      if (!rst_n)    sel <= '0;
      else if (take) sel <= sel + 1'b1;
   end

   // R10: a starved cycle leaves the lane position untouched
   p_hold_lane_r10: assert property (@(posedge clk) disable iff (!rst_n)
      starve |=> $stable(sel));
   // R3: lanes are walked in order, one per served cycle
   p_lane_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (sel == SW'($past(sel) + 1'b1)));
endmodule

// File: rtl/vid_wide_out.sv
module vid_wide_out
   import vout_pkg::*;
#(
   parameter int PPW      = 8,
   parameter int DEPTH    = 1024,
   parameter int H_ACTIVE = 640,
   parameter int H_FP     = 16,
   parameter int H_SYNC   = 96,
   parameter int H_TOTAL  = 800,
   parameter int V_ACTIVE = 480,
   parameter int V_FP     = 10,
   parameter int V_SYNC   = 2,
   parameter int V_TOTAL  = 585,
   parameter int PREFILL  = 16000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_valid,
   input  logic [PPW*PIX_W-1:0] wr_data,
   output logic                 wr_ready,
   input  logic                 underflow_clr,
   output logic                 underflow,
   output logic                 vid_de,
   output logic                 vid_hsync,
   output logic                 vid_vsync,
   output logic [PIX_W-1:0]     vid_rgb
);
   localparam int WORD_W = PPW * PIX_W;

   logic              active, hsync, vsync;
   logic [WORD_W-1:0] head;
   logic              empty, pop, starve;
   rgb_t              pix;

   vout_word_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_valid (wr_valid),
      .wr_data  (wr_data),
      .wr_ready (wr_ready),
      .rd_data  (head),
      .rd_empty (empty),
      .rd_pop   (pop)
   );

   vout_timing #(
      .H_ACTIVE (H_ACTIVE), .H_FP (H_FP), .H_SYNC (H_SYNC), .H_TOTAL (H_TOTAL),
      .V_ACTIVE (V_ACTIVE), .V_FP (V_FP), .V_SYNC (V_SYNC), .V_TOTAL (V_TOTAL),
      .PREFILL  (PREFILL)
   ) u_timing (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (active),
      .hsync  (hsync),
      .vsync  (vsync)
   );

   vout_unpack #(.PPW(PPW)) u_unpack (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (active),
      .word   (head),
      .empty  (empty),
      .pop    (pop),
      .starve (starve),
      .pix    (pix)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vid_de    <= 1'b0;
         vid_hsync <= 1'b0;
         vid_vsync <= 1'b0;
         vid_rgb   <= '0;
         underflow <= 1'b0;
      end else begin
         vid_de    <= active;
         vid_hsync <= hsync;
         vid_vsync <= vsync;
         vid_rgb   <= pix;
         if (starve)             underflow <= 1'b1;
         else if (underflow_clr) underflow <= 1'b0;
      end
   end

   // R8: a starved visible cycle shows black and raises the flag
   p_black_on_starve_r8: assert property (@(posedge clk) disable iff (!rst_n)
      starve |=> (vid_de && vid_rgb == '0 && underflow));
   // R8: the flag holds until cleared
   p_sticky_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (underflow && !underflow_clr) |=> underflow);
   // R9: a clear without new starvation drops the flag
   p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (underflow_clr && !starve) |=> !underflow);
   // R4: no sync pulse overlaps visible data
   p_de_no_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
      vid_de |-> (!vid_hsync && !vid_vsync));
endmodule

// File: tb/vid_wide_out_tb.sv
module vid_wide_out_tb;
   localparam int CLK_PERIOD = 10;
   localparam int PPW = 8;
   localparam int DEPTH = 8;
   localparam int HA = 16, HFP = 2, HS = 3, HT = 24;
   localparam int VA = 4, VFP = 1, VS = 1, VT = 8;
   localparam int PREFILL = 40;
   localparam int WW = PPW * 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_valid = 1'b0;
   logic [WW-1:0] wr_data = '0;
   logic          wr_ready;
   logic          underflow_clr = 1'b0;
   logic          underflow;
   logic          vid_de, vid_hsync, vid_vsync;
   logic [23:0]   vid_rgb;

   int errors = 0;
   int checks = 0;
   int exp_idx = 0;
   bit feed_on = 1'b0;
   bit allow_black = 1'b0;
   bit mon_on = 1'b0;
   int widx = 0;
   bit acc = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vid_wide_out #(
      .PPW(PPW), .DEPTH(DEPTH),
      .H_ACTIVE(HA), .H_FP(HFP), .H_SYNC(HS), .H_TOTAL(HT),
      .V_ACTIVE(VA), .V_FP(VFP), .V_SYNC(VS), .V_TOTAL(VT),
      .PREFILL(PREFILL)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
      .wr_ready(wr_ready), .underflow_clr(underflow_clr), .underflow(underflow),
      .vid_de(vid_de), .vid_hsync(vid_hsync), .vid_vsync(vid_vsync), .vid_rgb(vid_rgb)
   );

   function automatic logic [23:0] pix(int n);
      return 24'h800000 | 24'(n & 32'h7FFFFF);
   endfunction

   function automatic logic [WW-1:0] wordv(int w);
      logic [WW-1:0] r;
      for (int k = 0; k < PPW; k++) r[k*24 +: 24] = pix(w * PPW + k);
      return r;
   endfunction

   task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // Feeder: a word is accepted at a posedge when valid and ready were both high.
   always @(negedge clk) begin
      if (wr_valid && acc) widx++;
      wr_valid = feed_on;
      wr_data  = wordv(widx);
      acc      = wr_ready;
   end

   // Pixel stream monitor (R3, R6, R7, R10): every non-black pixel is the next in sequence.
   always @(negedge clk) begin
      if (rst_n && mon_on && vid_de) begin
         if (vid_rgb == 24'h0) begin
            check(allow_black, "R8 unexpected black", vid_rgb, pix(exp_idx));
         end else begin
            check(vid_rgb == pix(exp_idx), "R3 R6 R7 R10 pixel order", vid_rgb, pix(exp_idx));
            exp_idx++;
         end
      end
   end

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      check(!vid_de && !vid_hsync && !vid_vsync, "R1 syncs in reset",
            {vid_de, vid_hsync, vid_vsync}, 0);
      check(vid_rgb == 0 && !underflow, "R1 rgb/flag in reset", {underflow, vid_rgb}, 0);
      check(wr_ready == 1'b1, "R1 wr_ready in reset", wr_ready, 1);
   endtask

   task automatic t_prefill();
      bit quiet = 1'b1;
      rst_n   = 1'b1;
      feed_on = 1'b1;
      mon_on  = 1'b1;
      for (int k = 1; k <= PREFILL; k++) begin
         @(negedge clk);
         if (vid_de || vid_hsync || vid_vsync) quiet = 1'b0;
         if (k == 20) check(wr_ready == 1'b0, "R7 wr_ready low when full", wr_ready, 0);
      end
      check(quiet, "R2 outputs quiet during prefill", !quiet, 0);
      @(negedge clk);
      check(vid_de == 1'b1, "R2 first data enable after prefill", vid_de, 1);
   endtask

   task automatic t_line();
      int n;
      while (!(vid_de && !vid_hsync)) @(negedge clk);
      while (vid_de) @(negedge clk);
      while (!vid_de) @(negedge clk);
      n = 0;
      while (vid_de) begin n++; @(negedge clk); end
      check(n == HA, "R4 active width", n, HA);
      n = 0;
      while (!vid_hsync) begin n++; @(negedge clk); end
      check(n == HFP, "R4 front porch", n, HFP);
      n = 0;
      while (vid_hsync) begin n++; @(negedge clk); end
      check(n == HS, "R4 hsync width", n, HS);
      n = HA + HFP + HS;
      while (!vid_de) begin n++; @(negedge clk); end
      check(n == HT, "R4 line period", n, HT);
   endtask

   task automatic t_frame();
      int n, lines;
      bit prev;
      while (vid_vsync) @(negedge clk);
      while (!vid_vsync) @(negedge clk);
      n = 0;
      while (vid_vsync) begin n++; @(negedge clk); end
      check(n == VS * HT, "R5 vsync width", n, VS * HT);
      n = 0;
      while (!vid_de) begin n++; @(negedge clk); end
      check(n == (VT - VA - VFP - VS) * HT, "R5 back porch lines", n, (VT - VA - VFP - VS) * HT);
      lines = 0;
      prev = 1'b0;
      while (!vid_vsync) begin
         if (vid_de && !prev) lines++;
         prev = vid_de;
         n++;
         @(negedge clk);
      end
      check(lines == VA, "R5 active lines", lines, VA);
      check(n + VS * HT == VT * HT, "R5 frame period", n + VS * HT, VT * HT);
   endtask

   task automatic t_starve();
      int snap, guard;
      allow_black = 1'b1;
      feed_on = 1'b0;
      guard = 0;
      while (!underflow && guard < 2000) begin guard++; @(negedge clk); end
      check(vid_de && vid_rgb == 0 && underflow, "R8 black on starved cycle",
            {vid_de, vid_rgb}, {1'b1, 24'h0});
      snap = exp_idx;
      repeat (30) @(negedge clk);
      check(underflow == 1'b1, "R8 flag sticky", underflow, 1);
      feed_on = 1'b1;
      guard = 0;
      while (!(vid_de && vid_rgb != 0) && guard < 2000) begin guard++; @(negedge clk); end
      check(vid_rgb == pix(snap), "R10 resume at held pixel", vid_rgb, pix(snap));
      repeat (VT * HT) @(negedge clk);
      allow_black = 1'b0;
   endtask

   task automatic t_clear();
      bit stays = 1'b1;
      underflow_clr = 1'b1;
      @(negedge clk);
      underflow_clr = 1'b0;
      check(underflow == 1'b0, "R9 flag cleared", underflow, 0);
      repeat (2 * VT * HT) begin
         @(negedge clk);
         if (underflow) stays = 1'b0;
      end
      check(stays, "R9 flag stays clear with fed FIFO", !stays, 0);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual=expired expected=done");
      finish_run();
   end

   initial begin
      t_reset();
      t_prefill();
      t_line();
      t_frame();
      t_starve();
      t_clear();
      check(exp_idx > 4 * VA * HA, "R6 pixels streamed over frames", exp_idx, 4 * VA * HA);
      finish_run();
   end
endmodule